// File: doc/BRIEF.md
# Load Issue and Split Access Controller

This block takes a load that could not be satisfied from older stores and sends it to a data cache port. The cache may refuse any packet. An aligned load goes out as one packet. A misaligned load goes out as two packets: a low half and a high half. The high half starts at the base address plus the low-half size, and its data lands at that same byte offset. A pending counter holds the number of halves still owed a response. The load completes when that counter reaches zero.

Uncacheable loads are gated. Such a load is only sent when it is both the oldest load in the queue and ready to commit. Otherwise the block asks the scheduler to replay it and raises a fault indication.

A refused packet produces a retry request. A refused first packet abandons the whole load. A refused second packet only removes one expected response.

Every refusal also goes to a recorder, which remembers the oldest blocked load by sequence number. The recorder has a handled flag that an external acknowledge sets. The block tracks one access at a time and accepts no new load until that access has finished or been abandoned.

Top module: `load_issue_ctrl`

## Requirements
- R1: After reset, `ld_ready_o` is 1 and every other output is 0, including the blocked record (valid, sequence, handled).
- R2: An accepted load with `ld_uncached_i`=1 that does not have both `ld_at_head_i` and `ld_at_commit_i` high is not sent.
  - In the cycle after acceptance, `resched_o` and `fault_o` pulse high for exactly one cycle.
  - No cache packet is issued for that load.
- R3: An accepted aligned load is presented as one packet in the cycle after acceptance, with the load's address and size and offset 0. `mem_req_valid_o` is high for exactly that cycle. If `mem_ready_i` is high in that cycle, one response on `mem_resp_i` gives a one-cycle `done_o` pulse in the following cycle.
- R4: A split load (`ld_split_i`=1) is sent as two packets on consecutive cycles.
  - The low half carries the base address, size `ld_lo_size_i` and offset 0.
  - The high half carries base plus low size, size `ld_size_i` minus low size, and offset equal to the low size.
  - The pending count starts at 2. `done_o` waits for both responses.
- R5: If the first packet is refused (`mem_ready_i`=0 while it is presented), the load is dropped.
  - `retry_o` pulses in the next cycle.
  - No second packet follows and `done_o` never pulses.
  - `ld_ready_o` returns to 1.
- R6: If the high half is refused, `retry_o` pulses in the next cycle and the pending count drops by one, so a single response completes the load.
- R7: `mem_req_cmd_o` is 2'd1 for an ordinary read and 2'd2 for a load-locked request (`ld_locked_i`=1).
- R8: On each refusal, the load's sequence number is recorded if no record is held or if it is numerically smaller than the held one. A larger (younger) sequence number leaves the record unchanged. `blk_clear_i` drops the record.
- R9: Taking a new record clears `blk_handled_o`. A `blk_ack_i` pulse sets it.
- R10: `ld_ready_o` is 0 from the cycle after acceptance until the cycle in which the access completes or is abandoned. No load is accepted in that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Load request offered |
| ld_ready_o | output | 1 | Block is idle and takes the request |
| ld_addr_i | input | AW | Load byte address |
| ld_size_i | input | SZW | Total load size in bytes |
| ld_split_i | input | 1 | Load must be sent as two halves |
| ld_lo_size_i | input | SZW | Size of the low half when split |
| ld_uncached_i | input | 1 | Load targets uncacheable memory |
| ld_locked_i | input | 1 | Load-locked request |
| ld_seq_i | input | SQW | Load sequence number (smaller is older) |
| ld_at_head_i | input | 1 | Load is the oldest in the load queue |
| ld_at_commit_i | input | 1 | Load is ready to commit |
| mem_req_valid_o | output | 1 | Cache packet presented this cycle |
| mem_req_cmd_o | output | 2 | Packet command: 1 read, 2 load-locked |
| mem_req_addr_o | output | AW | Packet address |
| mem_req_size_o | output | SZW | Packet size in bytes |
| mem_req_offset_o | output | SZW | Byte offset of packet data in the load buffer |
| mem_ready_i | input | 1 | Cache accepts the presented packet |
| mem_resp_i | input | 1 | One packet response returned |
| resched_o | output | 1 | Pulse: replay the load later |
| fault_o | output | 1 | Pulse: machine-check style fault for a gated load |
| retry_o | output | 1 | Pulse: cache refused, retry for this thread |
| done_o | output | 1 | Pulse: all halves of the load have responded |
| blk_valid_o | output | 1 | A blocked load is recorded |
| blk_seq_o | output | SQW | Sequence number of the recorded blocked load |
| blk_handled_o | output | 1 | Recorded blocked load has been handled |
| blk_ack_i | input | 1 | Marks the recorded blocked load as handled |
| blk_clear_i | input | 1 | Drops the blocked record |

## Verification
The hardest case to reach from the ports is a split load whose low half is accepted and whose high half is refused. Reaching it needs the cache ready level to change between two consecutive presented packets, with no response arriving in between. Only then does the single remaining response complete the load.

The bench drives `mem_ready_i` separately on each packet cycle. It sweeps every accept/refuse pairing against every uncacheable gating combination. It varies sequence numbers, so refusals arrive both older and younger than the held record.

// File: rtl/ldi_pkg.sv
package ldi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_WAIT = 2'd3
  } ldi_state_e;

  localparam logic [1:0] CMD_READ   = 2'd1;
  localparam logic [1:0] CMD_LOCKED = 2'd2;
endpackage

// File: rtl/ldi_packet_gen.sv
module ldi_packet_gen #(
  parameter int AW  = 32,
  parameter int SZW = 4
) (
  input  logic [AW-1:0]  base_addr,
  input  logic [SZW-1:0] total_size,
  input  logic [SZW-1:0] lo_size,
  input  logic           split,
  input  logic           hi_sel,
  output logic [AW-1:0]  pkt_addr,
  output logic [SZW-1:0] pkt_size,
  output logic [SZW-1:0] pkt_offset
);
  localparam int PADW = AW - SZW;

  logic [AW-1:0] lo_ext;
  assign lo_ext = {{PADW{1'b0}}, lo_size};

  always_comb begin
    pkt_addr   = base_addr;
    pkt_size   = total_size;
    pkt_offset = '0;
    if (split) begin
      if (hi_sel) begin
        pkt_addr   = base_addr + lo_ext;
        pkt_size   = total_size - lo_size;
        pkt_offset = lo_size;
      end else begin
        pkt_size = lo_size;
      end
    end
  end
endmodule

// File: rtl/ldi_pending_ctr.sv
module ldi_pending_ctr #(
  parameter int MAXO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic load_two,
  input  logic active,
  input  logic dec_resp,
  input  logic dec_refuse,
  output logic [$clog2(MAXO+1)-1:0] cnt_o,
  output logic zero_next
);
  localparam int CW = $clog2(MAXO + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dec_amt;
  logic [CW-1:0] cnt_dec;

  assign dec_amt   = CW'(dec_resp) + CW'(dec_refuse);
  assign cnt_dec   = (cnt_q > dec_amt) ? cnt_q - dec_amt : '0;
  assign zero_next = active && (cnt_dec == '0);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_two ? CW'(2) : CW'(1);
    end else if (active) begin
      cnt_q <= cnt_dec;
    end
  end

  // R4
  cnt_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXO));

  // R6
  refuse_drops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (active && dec_refuse && !dec_resp && cnt_q == CW'(2)) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/ldi_block_rec.sv
module ldi_block_rec #(
  parameter int SQW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           record_en,
  input  logic [SQW-1:0] seq_i,
  input  logic           ack_i,
  input  logic           clear_i,
  output logic           valid_o,
  output logic [SQW-1:0] seq_o,
  output logic           handled_o
);
  logic           valid_q;
  logic [SQW-1:0] seq_q;
  logic           handled_q;
  logic           take;

  assign take = record_en && (!valid_q || (seq_i < seq_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      seq_q     <= '0;
      handled_q <= 1'b0;
    end else begin
      if (take) begin
        valid_q   <= 1'b1;
        seq_q     <= seq_i;
        handled_q <= 1'b0;
      end else begin
        if (clear_i) valid_q <= 1'b0;
        if (ack_i) handled_q <= 1'b1;
      end
    end
  end

  assign valid_o   = valid_q;
  assign seq_o     = seq_q;
  assign handled_o = handled_q;

  // R8
  older_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q) && !$past(clear_i)) |-> (seq_q <= $past(seq_q)));

  // R9
  ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !record_en) |=> handled_q);
endmodule

// File: rtl/load_issue_ctrl.sv
module load_issue_ctrl
  import ldi_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 4,
  parameter int SQW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid_i,
  output logic           ld_ready_o,
  input  logic [AW-1:0]  ld_addr_i,
  input  logic [SZW-1:0] ld_size_i,
  input  logic           ld_split_i,
  input  logic [SZW-1:0] ld_lo_size_i,
  input  logic           ld_uncached_i,
  input  logic           ld_locked_i,
  input  logic [SQW-1:0] ld_seq_i,
  input  logic           ld_at_head_i,
  input  logic           ld_at_commit_i,
  output logic           mem_req_valid_o,
  output logic [1:0]     mem_req_cmd_o,
  output logic [AW-1:0]  mem_req_addr_o,
  output logic [SZW-1:0] mem_req_size_o,
  output logic [SZW-1:0] mem_req_offset_o,
  input  logic           mem_ready_i,
  input  logic           mem_resp_i,
  output logic           resched_o,
  output logic           fault_o,
  output logic           retry_o,
  output logic           done_o,
  output logic           blk_valid_o,
  output logic [SQW-1:0] blk_seq_o,
  output logic           blk_handled_o,
  input  logic           blk_ack_i,
  input  logic           blk_clear_i
);
  localparam int MAXO = 2;
  localparam int CW   = $clog2(MAXO + 1);

  ldi_state_e     state_q;
  logic [AW-1:0]  addr_q;
  logic [SZW-1:0] size_q;
  logic [SZW-1:0] lo_q;
  logic           split_q;
  logic [SQW-1:0] seq_q;

  logic           accept;
  logic           allow;
  logic           in_lo;
  logic           in_hi;
  logic           in_wait;
  logic           refused;

  logic [AW-1:0]  gen_base;
  logic [SZW-1:0] gen_total;
  logic [SZW-1:0] gen_lo;
  logic           gen_split;
  logic [AW-1:0]  pkt_addr;
  logic [SZW-1:0] pkt_size;
  logic [SZW-1:0] pkt_offset;

  logic [CW-1:0]  pend_cnt;
  logic           pend_zero;

  assign ld_ready_o = (state_q == ST_IDLE);
  assign accept     = ld_valid_i && ld_ready_o;
  assign allow      = !ld_uncached_i || (ld_at_head_i && ld_at_commit_i);
  assign in_lo      = (state_q == ST_LO);
  assign in_hi      = (state_q == ST_HI);
  assign in_wait    = (state_q == ST_WAIT);
  assign refused    = (in_lo || in_hi) && !mem_ready_i;

  // Idle: build the first packet from the live request; low phase: the high half.
  assign gen_base  = in_lo ? addr_q  : ld_addr_i;
  assign gen_total = in_lo ? size_q  : ld_size_i;
  assign gen_lo    = in_lo ? lo_q    : ld_lo_size_i;
  assign gen_split = in_lo ? split_q : ld_split_i;

  ldi_packet_gen #(.AW(AW), .SZW(SZW)) u_pkt (
    .base_addr (gen_base),
    .total_size(gen_total),
    .lo_size   (gen_lo),
    .split     (gen_split),
    .hi_sel    (in_lo),
    .pkt_addr  (pkt_addr),
    .pkt_size  (pkt_size),
    .pkt_offset(pkt_offset)
  );

  ldi_pending_ctr #(.MAXO(MAXO)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .load_en   (in_lo && mem_ready_i),
    .load_two  (split_q),
    .active    (in_hi || in_wait),
    .dec_resp  (mem_resp_i && (in_hi || in_wait)),
    .dec_refuse(in_hi && !mem_ready_i),
    .cnt_o     (pend_cnt),
    .zero_next (pend_zero)
  );

  ldi_block_rec #(.SQW(SQW)) u_blk (
    .clk      (clk),
    .rst      (rst),
    .record_en(refused),
    .seq_i    (seq_q),
    .ack_i    (blk_ack_i),
    .clear_i  (blk_clear_i),
    .valid_o  (blk_valid_o),
    .seq_o    (blk_seq_o),
    .handled_o(blk_handled_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      addr_q           <= '0;
      size_q           <= '0;
      lo_q             <= '0;
      split_q          <= 1'b0;
      seq_q            <= '0;
      mem_req_valid_o  <= 1'b0;
      mem_req_cmd_o    <= 2'd0;
      mem_req_addr_o   <= '0;
      mem_req_size_o   <= '0;
      mem_req_offset_o <= '0;
      resched_o        <= 1'b0;
      fault_o          <= 1'b0;
      retry_o          <= 1'b0;
      done_o           <= 1'b0;
    end else begin
      resched_o <= 1'b0;
      fault_o   <= 1'b0;
      retry_o   <= 1'b0;
      done_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          mem_req_valid_o <= 1'b0;
          if (accept) begin
            if (allow) begin
              addr_q           <= ld_addr_i;
              size_q           <= ld_size_i;
              lo_q             <= ld_lo_size_i;
              split_q          <= ld_split_i;
              seq_q            <= ld_seq_i;
              mem_req_valid_o  <= 1'b1;
              mem_req_cmd_o    <= ld_locked_i ? CMD_LOCKED : CMD_READ;
              mem_req_addr_o   <= pkt_addr;
              mem_req_size_o   <= pkt_size;
              mem_req_offset_o <= pkt_offset;
              state_q          <= ST_LO;
            end else begin
              resched_o <= 1'b1;
              fault_o   <= 1'b1;
            end
          end
        end
        ST_LO: begin
          if (mem_ready_i && split_q) begin
            mem_req_valid_o  <= 1'b1;
            mem_req_addr_o   <= pkt_addr;
            mem_req_size_o   <= pkt_size;
            mem_req_offset_o <= pkt_offset;
            state_q          <= ST_HI;
          end else if (mem_ready_i) begin
            mem_req_valid_o <= 1'b0;
            state_q         <= ST_WAIT;
          end else begin
            mem_req_valid_o <= 1'b0;
            retry_o         <= 1'b1;
            state_q         <= ST_IDLE;
          end
        end
        ST_HI: begin
          mem_req_valid_o <= 1'b0;
          if (!mem_ready_i) retry_o <= 1'b1;
          if (pend_zero) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          mem_req_valid_o <= 1'b0;
          if (pend_zero) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  gated_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $past(accept && !allow) |-> (resched_o && fault_o && !mem_req_valid_o));

  // R5
  retry_cause_chk: assert property (@(posedge clk) disable iff (rst)
    retry_o |-> $past(mem_req_valid_o && !mem_ready_i));

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> !ld_ready_o);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ld_ready_o && !mem_req_valid_o));

  // R4
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid_o && mem_req_offset_o != '0) |-> $past(mem_req_valid_o && mem_ready_i));

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req_valid_o, resched_o, done_o}));

  // R4
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> (pend_cnt != '0));
endmodule

// File: tb/tb_load_issue_ctrl.sv
module tb_load_issue_ctrl;
  localparam int AW  = 32;
  localparam int SZW = 4;
  localparam int SQW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_valid_i = 1'b0;
  logic           ld_ready_o;
  logic [AW-1:0]  ld_addr_i = '0;
  logic [SZW-1:0] ld_size_i = '0;
  logic           ld_split_i = 1'b0;
  logic [SZW-1:0] ld_lo_size_i = '0;
  logic           ld_uncached_i = 1'b0;
  logic           ld_locked_i = 1'b0;
  logic [SQW-1:0] ld_seq_i = '0;
  logic           ld_at_head_i = 1'b0;
  logic           ld_at_commit_i = 1'b0;
  logic           mem_req_valid_o;
  logic [1:0]     mem_req_cmd_o;
  logic [AW-1:0]  mem_req_addr_o;
  logic [SZW-1:0] mem_req_size_o;
  logic [SZW-1:0] mem_req_offset_o;
  logic           mem_ready_i = 1'b0;
  logic           mem_resp_i = 1'b0;
  logic           resched_o, fault_o, retry_o, done_o;
  logic           blk_valid_o;
  logic [SQW-1:0] blk_seq_o;
  logic           blk_handled_o;
  logic           blk_ack_i = 1'b0;
  logic           blk_clear_i = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic           e_bv = 1'b0;
  logic [SQW-1:0] e_bs = '0;
  logic           e_bh = 1'b0;

  always #10 clk = ~clk;

  load_issue_ctrl #(.AW(AW), .SZW(SZW), .SQW(SQW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic note_refusal(input logic [SQW-1:0] s);
    if (!e_bv || s < e_bs) begin
      e_bv = 1'b1;
      e_bs = s;
      e_bh = 1'b0;
    end
  endtask

  task automatic check_blk(input string req);
    chk({req, " blk_valid"}, blk_valid_o, e_bv);
    if (e_bv) chk({req, " blk_seq"}, blk_seq_o, e_bs);
    chk({req, " blk_handled"}, blk_handled_o, e_bh);
  endtask

  task automatic run_load(input logic [AW-1:0] a, input logic [SZW-1:0] sz,
                          input logic sp, input logic [SZW-1:0] lo,
                          input logic unc, input logic hd, input logic cm,
                          input logic lk, input logic [SQW-1:0] s,
                          input logic r1, input logic r2);
    logic [1:0] ecmd;
    int nresp;
    ecmd = lk ? 2'd2 : 2'd1;
    @(negedge clk);
    chk("R10 ready when idle", ld_ready_o, 1'b1);
    ld_valid_i = 1'b1; ld_addr_i = a; ld_size_i = sz; ld_split_i = sp;
    ld_lo_size_i = lo; ld_uncached_i = unc; ld_at_head_i = hd;
    ld_at_commit_i = cm; ld_locked_i = lk; ld_seq_i = s;
    @(negedge clk);
    ld_valid_i = 1'b0;
    if (unc && !(hd && cm)) begin
      chk("R2 resched", resched_o, 1'b1);
      chk("R2 fault", fault_o, 1'b1);
      chk("R2 no packet", mem_req_valid_o, 1'b0);
      @(negedge clk);
      chk("R2 pulse one cycle", {resched_o, fault_o, mem_req_valid_o}, 3'b000);
      return;
    end
    chk("R3 first packet valid", mem_req_valid_o, 1'b1);
    chk("R3 first addr", mem_req_addr_o, a);
    chk("R4 first size", mem_req_size_o, sp ? lo : sz);
    chk("R3 first offset", mem_req_offset_o, 0);
    chk("R7 cmd", mem_req_cmd_o, ecmd);
    chk("R10 busy", ld_ready_o, 1'b0);
    mem_ready_i = r1;
    @(negedge clk);
    mem_ready_i = 1'b0;
    if (!r1) begin
      note_refusal(s);
      chk("R5 retry", retry_o, 1'b1);
      chk("R5 no second packet", mem_req_valid_o, 1'b0);
      chk("R5 ready again", ld_ready_o, 1'b1);
      chk("R5 no done", done_o, 1'b0);
      check_blk("R8 refusal lo");
      return;
    end
    nresp = 1;
    if (sp) begin
      chk("R4 second valid", mem_req_valid_o, 1'b1);
      chk("R4 second addr", mem_req_addr_o, a + AW'(lo));
      chk("R4 second size", mem_req_size_o, sz - lo);
      chk("R4 second offset", mem_req_offset_o, lo);
      chk("R7 second cmd", mem_req_cmd_o, ecmd);
      mem_ready_i = r2;
      @(negedge clk);
      mem_ready_i = 1'b0;
      chk("R6 retry on high", retry_o, !r2);
      chk("R4 packet ends", mem_req_valid_o, 1'b0);
      if (!r2) begin
        note_refusal(s);
        check_blk("R8 refusal hi");
      end
      nresp = r2 ? 2 : 1;
    end else begin
      chk("R3 single packet", mem_req_valid_o, 1'b0);
      chk("R3 no retry", retry_o, 1'b0);
    end
    for (int i = 0; i < nresp; i++) begin
      chk("R4 not done early", done_o, 1'b0);
      chk("R10 busy waiting", ld_ready_o, 1'b0);
      mem_resp_i = 1'b1;
      @(negedge clk);
      mem_resp_i = 1'b0;
    end
    chk("R3 done pulse", done_o, 1'b1);
    chk("R10 ready after done", ld_ready_o, 1'b1);
    @(negedge clk);
    chk("R3 done one cycle", done_o, 1'b0);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    blk_ack_i = 1'b1;
    @(negedge clk);
    blk_ack_i = 1'b0;
    e_bh = 1'b1;
    chk("R9 ack sets handled", blk_handled_o, 1'b1);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    blk_clear_i = 1'b1;
    @(negedge clk);
    blk_clear_i = 1'b0;
    e_bv = 1'b0;
    chk("R8 clear drops record", blk_valid_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", ld_ready_o, 1'b1);
    chk("R1 outputs quiet", {mem_req_valid_o, resched_o, fault_o, retry_o, done_o}, 5'b0);
    chk("R1 req fields", {mem_req_cmd_o, mem_req_addr_o, mem_req_size_o, mem_req_offset_o}, 0);
    check_blk("R1 blk");

    k = 0;
    for (int u = 0; u < 2; u++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 2; c++)
          for (int sp = 0; sp < 2; sp++)
            for (int r1 = 0; r1 < 2; r1++)
              for (int r2 = 0; r2 < 2; r2++) begin
                logic [SZW-1:0] lo, sz;
                logic [SQW-1:0] s;
                lo = SZW'(1 + (k % 7));
                sz = sp ? SZW'(8) : SZW'(1 << (k % 4));
                s  = SQW'((k * 37 + 11) % 256);
                run_load(AW'(32'h1000 + k * 13), sz, sp[0], lo, u[0], h[0], c[0],
                         (k % 3) == 0, s, r1[0], r2[0]);
                if (k % 5 == 1 && e_bv) pulse_ack();
                if (k % 8 == 7) pulse_clear();
                k++;
              end

    pulse_clear();
    run_load(32'h2000, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0);
    chk("R8 first record", blk_seq_o, 20);
    pulse_ack();
    run_load(32'h2004, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd30, 1'b0, 1'b0);
    chk("R8 younger ignored seq", blk_seq_o, 20);
    chk("R9 younger keeps handled", blk_handled_o, 1'b1);
    run_load(32'h2008, 4'd8, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 1'b0);
    chk("R8 older replaces", blk_seq_o, 10);
    chk("R9 new record clears handled", blk_handled_o, 1'b0);
    run_load(32'h3000, 4'd2, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd5, 1'b1, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule